// File: doc/BRIEF.md
# Configurable Order Sinc Decimator

This block low-pass filters and decimates a stream of small signed samples (a one-bit modulator stream mapped to two-bit signed values, or any narrow signed input). Each accepted sample goes into a cascade of running-sum integrators at the input rate. Every R-th accepted sample, the selected integrator output is passed to a cascade of differencing combs at the output rate, and the result comes out as one wide signed sample.

The filter type comes from a 3-bit code. Codes 1 to 5 select a sinc filter of that order, H(z) = ((1 - z^-R)/(1 - z^-1))^k. Code 0 selects a fast mode: a second-order sinc followed by a (1 + z^-2R) stage, which is formed at the output rate by adding the comb result from two output samples earlier. Codes 6 and 7 are reserved. The ratio field is 10 bits wide and R is the field value plus one. The type and the ratio are taken in only while the enable input is low. Lowering the enable clears all filter state.

Both data paths use valid/ready. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. An output sample is held, unchanged, until a clock edge where `out_ready` is high. While an output is waiting and `out_ready` is low, `in_ready` is low, so the input side is stalled and no sample is lost.

Top module: `sinc_decimator`

## Requirements
- R1: The captured type code selects the filter: 0 is fast mode, 1 to 5 are sinc order 1 to 5, and 6 and 7 are reserved.
- R2: For sinc order k, each output equals the sum, over all accepted samples since enable, of the sample times the coefficient of (1 + z^-1 + ... + z^-(R-1))^k. Samples before enable count as zero, and output m is aligned to the (m·R)-th accepted sample.
- R3: In fast mode, each output equals the order-2 result described in R2 plus the order-2 result at the same instant computed with a kernel shifted by 2R input samples. This is the kernel of the second-order sinc times (1 + z^-2R).
- R4: The decimation ratio R is the 10-bit ratio field value plus one, so R runs from 1 to 1024. Exactly one decimation instant occurs per R accepted samples.
- R5: After each enable, the first k decimation instants produce no output for sinc order k, and the first 4 produce none in fast mode.
- R6: The type code and ratio field are captured on every clock edge where `en` is low. Changes made while `en` is high have no effect on the output.
- R7: A clock edge with `en` low clears integrators, combs, counters and any pending output. The next enable starts from zero state.
- R8: With sinc order 5, R = 1024 and a constant full-scale input of -2 or +1, the output is exactly the input times 2^50, with no wrap-around.
- R9: `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. A pending output keeps `out_valid` and `out_data` stable until it is taken.
- R10: While a reserved code (6 or 7) is captured, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Filter enable; low clears state and captures configuration |
| order_sel | input | 3 | Filter type code (0 fast, 1-5 sinc order, 6-7 reserved) |
| osr_sel | input | 10 | Ratio field, R = value + 1 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample can be accepted |
| in_data | input | 2 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | 53 | Signed filtered sample |

## Verification
The bench uses a direct convolution model with a kernel built by repeated box-car sums. Any misplaced integrator delay, wrong decimation phase or off-by-one in R shows up as a wrong value at the first unsuppressed output. Random valid and ready gaps check that a stalled input keeps the decimation phase; a design that dropped or doubled a sample under back-pressure would drift from the model. The fast mode checks that the extra term uses the comb value from exactly two output samples back. The order-5, R = 1024 run at both full-scale polarities exposes any accumulator too narrow to hold the gain. Configuration changes made while enabled, a disable in the middle of a run and the reserved codes confirm that stale state or a config change taken at the wrong time never reaches the output.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_FAST  = 3'd0,
    KIND_SINC1 = 3'd1,
    KIND_SINC2 = 3'd2,
    KIND_SINC3 = 3'd3,
    KIND_SINC4 = 3'd4,
    KIND_SINC5 = 3'd5,
    KIND_RSV6  = 3'd6,
    KIND_RSV7  = 3'd7
  } flt_kind_e;

  // Decimation instants discarded after enable while comb delays fill.
  function automatic logic [KIND_W-1:0] fill_of(input flt_kind_e k);
    return (k == KIND_FAST) ? 3'd4 : k;
  endfunction

  // Integrator/comb depth actually used by a filter kind.
  function automatic logic [KIND_W-1:0] depth_of(input flt_kind_e k);
    return (k == KIND_FAST) ? 3'd2 : k;
  endfunction

endpackage

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
  parameter int IN_W   = 2,
  parameter int ACC_W  = 53,
  parameter int STAGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [IN_W-1:0]  x,
  input  logic [2:0]       sel,
  output logic [ACC_W-1:0] tap
);

  // nxt[k] is the value integrator k takes on this step; the taps are
  // combinational so the current sample is already inside the sum.
  logic [ACC_W-1:0] nxt [0:STAGES];

  assign nxt[0] = {{(ACC_W-IN_W){x[IN_W-1]}}, x};

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    logic [ACC_W-1:0] acc;
    assign nxt[k] = acc + nxt[k-1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (clr)   acc <= '0;
      else if (step)  acc <= nxt[k];
    end
  end

  always_comb begin
    tap = '0;
    for (int k = 1; k <= STAGES; k++) begin
      if (sel == 3'(k)) tap = nxt[k];
    end
  end

endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
  parameter int ACC_W  = 53,
  parameter int STAGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [ACC_W-1:0] din,
  input  logic [2:0]       sel,
  input  logic             fast,
  output logic [ACC_W-1:0] y
);

  logic [ACC_W-1:0] c [0:STAGES];
  logic [ACC_W-1:0] hist1, hist2;

  assign c[0] = din;

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    logic [ACC_W-1:0] dly;
    assign c[k] = c[k-1] - dly;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dly <= '0;
      else if (clr)   dly <= '0;
      else if (step)  dly <= c[k-1];
    end
  end

  // Two-deep history of the second comb output for the (1 + z^-2R) term.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1 <= '0;
      hist2 <= '0;
    end else if (clr) begin
      hist1 <= '0;
      hist2 <= '0;
    end else if (step) begin
      hist1 <= c[2];
      hist2 <= hist1;
    end
  end

  always_comb begin
    y = '0;
    for (int k = 1; k <= STAGES; k++) begin
      if (sel == 3'(k)) y = c[k];
    end
    if (fast) y = c[2] + hist2;
  end

endmodule

// File: rtl/sinc_dec_ctrl.sv
module sinc_dec_ctrl #(
  parameter int OSR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [OSR_W-1:0] osr,
  input  logic [2:0]       fill,
  input  logic             kind_ok,
  output logic             hit,
  output logic             emit
);

  logic [OSR_W-1:0] phase;
  logic [2:0]       seen;

  assign hit  = step && (phase == osr);
  assign emit = hit && kind_ok && (seen >= fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= '0;
    else if (clr)   phase <= '0;
    else if (step)  phase <= hit ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    seen <= '0;
    else if (clr)                  seen <= '0;
    else if (hit && seen != 3'd7)  seen <= seen + 3'd1;
  end

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_dec_pkg::*;
#(
  parameter  int IN_W    = 2,
  parameter  int OSR_W   = 10,
  parameter  int MAX_ORD = 5,
  localparam int ACC_W   = IN_W + MAX_ORD * OSR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       order_sel,
  input  logic [OSR_W-1:0] osr_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data
);

  flt_kind_e        kind_q;
  logic [OSR_W-1:0] osr_q;
  logic             kind_ok, fast, clr, step, hit, emit;
  logic [2:0]       depth, fill;
  logic [ACC_W-1:0] tap, comb_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_SINC1;
      osr_q  <= '0;
    end else if (!en) begin
      kind_q <= flt_kind_e'(order_sel);
      osr_q  <= osr_sel;
    end
  end

  assign kind_ok  = (kind_q == KIND_FAST) || (kind_q <= 3'(MAX_ORD));
  assign fast     = (kind_q == KIND_FAST);
  assign depth    = depth_of(kind_q);
  assign fill     = fill_of(kind_q);
  assign clr      = !en;
  assign in_ready = !(out_valid && !out_ready);
  assign step     = en && in_valid && in_ready;

  sinc_integ_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(MAX_ORD)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .x(in_data), .sel(depth), .tap(tap)
  );

  sinc_dec_ctrl #(.OSR_W(OSR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .osr(osr_q), .fill(fill), .kind_ok(kind_ok),
    .hit(hit), .emit(emit)
  );

  sinc_comb_chain #(.ACC_W(ACC_W), .STAGES(MAX_ORD)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(hit),
    .din(tap), .sel(depth), .fast(fast), .y(comb_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (!en) begin
      out_valid <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= comb_y;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sinc_decimator_chk.sv
module sinc_decimator_chk #(
  parameter int ACC_W = 53,
  parameter int OSR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data,
  input logic [2:0]       kind_q,
  input logic [OSR_W-1:0] osr_q
);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid);

  assert_frozen_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(kind_q) && $stable(osr_q)));

  assert_reserved_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q > 3'd5) |-> !out_valid);

endmodule

bind sinc_decimator sinc_decimator_chk #(.ACC_W(ACC_W), .OSR_W(OSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .kind_q(kind_q), .osr_q(osr_q)
);

// File: tb/sinc_decimator_tb_top.sv
module sinc_decimator_tb_top;

  localparam int IN_W  = 2;
  localparam int OSR_W = 10;
  localparam int ACC_W = IN_W + 5 * OSR_W + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, en, in_valid, in_ready, out_valid, out_ready;
  logic [2:0]       order_sel;
  logic [OSR_W-1:0] osr_sel;
  logic [IN_W-1:0]  in_data;
  logic [ACC_W-1:0] out_data;

  sinc_decimator dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .order_sel(order_sel), .osr_sel(osr_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int        checks = 0;
  int        errors = 0;
  string     tag = "R9";
  bit        done = 0;
  bit [15:0] lfsr = 16'hACE1;

  // Reference model state
  longint hist[$];
  longint kern[];
  bit     kdirty = 1;
  bit     m_ov = 0;
  longint m_data = 0;
  int     m_dec = 0;
  int     m_kind = 1;
  int     m_osr = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void build_kernel();
    longint f[];
    longint g[];
    int r = m_osr + 1;
    int k = (m_kind == 0) ? 2 : m_kind;
    f = new[1];
    f[0] = 1;
    for (int s = 0; s < k; s++) begin
      longint w;
      g = new[f.size() + r - 1];
      w = 0;
      for (int n = 0; n < g.size(); n++) begin
        if (n < f.size()) w += f[n];
        if (n - r >= 0 && n - r < f.size()) w -= f[n-r];
        g[n] = w;
      end
      f = g;
    end
    if (m_kind == 0) begin
      g = new[f.size() + 2 * r];
      for (int n = 0; n < g.size(); n++) begin
        g[n] = 0;
        if (n < f.size()) g[n] += f[n];
        if (n >= 2 * r && n - 2 * r < f.size()) g[n] += f[n-2*r];
      end
      f = g;
    end
    kern = f;
  endfunction

  function automatic longint fir();
    longint y = 0;
    int nh = hist.size();
    for (int j = 0; j < kern.size() && j < nh; j++) y += kern[j] * hist[nh-1-j];
    return y;
  endfunction

  task automatic cyc(input bit e, input int kind, input int osr, input bit v,
                     input int s, input bit rdy);
    bit exp_rdy;
    int fill;
    en = e; order_sel = 3'(kind); osr_sel = OSR_W'(osr);
    in_valid = v; in_data = IN_W'(s); out_ready = rdy;
    exp_rdy = !(m_ov && !rdy);
    #1;
    check(in_ready == exp_rdy, "in_ready", longint'(in_ready), longint'(exp_rdy));
    if (!e) begin
      m_kind = kind; m_osr = osr;
      hist.delete(); m_dec = 0; m_ov = 0; kdirty = 1;
    end else begin
      if (kdirty) begin
        if (m_kind <= 5) build_kernel();
        kdirty = 0;
      end
      if (m_ov && rdy) m_ov = 0;
      if (v && exp_rdy) begin
        hist.push_back(longint'(s));
        if (hist.size() % (m_osr + 1) == 0) begin
          m_dec++;
          fill = (m_kind == 0) ? 4 : m_kind;
          if (m_kind <= 5 && m_dec > fill) begin
            m_ov = 1;
            m_data = fir();
          end
        end
      end
    end
    @(negedge clk);
    check(out_valid == m_ov, "out_valid", longint'(out_valid), longint'(m_ov));
    if (m_ov && out_valid)
      check($signed(out_data) == m_data, "out_data", longint'($signed(out_data)), m_data);
  endtask

  // Disable for two cycles with (kind, osr), then run n enabled cycles while
  // driving (kind_live, osr_live) on the configuration pins.
  task automatic run(input int kind, input int osr, input int kind_live, input int osr_live,
                     input int n, input bit rand_v, input bit rand_r,
                     input bit use_const, input int const_s);
    cyc(0, kind, osr, 0, 0, 1);
    cyc(0, kind, osr, 0, 0, 1);
    for (int i = 0; i < n; i++) begin
      bit v, r;
      int s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = rand_v ? (lfsr[0] | lfsr[3]) : 1'b1;
      r = rand_r ? (lfsr[5] | lfsr[1]) : 1'b1;
      s = use_const ? const_s : int'($signed(lfsr[9:8]));
      cyc(1, kind_live, osr_live, v, s, r);
    end
  endtask

  initial begin
    rst_n = 0; en = 0; order_sel = 3'd1; osr_sel = '0;
    in_valid = 0; in_data = '0; out_ready = 1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "reset out_valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "reset in_ready", longint'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);

    tag = "R2"; run(1, 3, 1, 3, 60, 0, 0, 0, 0);     // sinc1, R=4
    tag = "R2"; run(3, 4, 3, 4, 120, 0, 0, 0, 0);    // sinc3, R=5
    tag = "R2"; run(5, 1, 5, 1, 80, 0, 0, 0, 0);     // sinc5, R=2
    tag = "R1"; run(4, 2, 4, 2, 90, 1, 0, 0, 0);     // code 4 -> sinc4
    tag = "R3"; run(0, 2, 0, 2, 120, 0, 0, 0, 0);    // fast, R=3
    tag = "R3"; run(0, 0, 0, 0, 40, 1, 1, 0, 0);     // fast, R=1
    tag = "R4"; run(1, 0, 1, 0, 30, 0, 0, 0, 0);     // R=1: every sample
    tag = "R4"; run(2, 6, 2, 6, 100, 0, 0, 0, 0);    // R=7
    tag = "R5"; run(3, 1, 3, 1, 10, 0, 0, 1, 1);     // 5 instants, 2 outputs
    tag = "R9"; run(2, 1, 2, 1, 200, 1, 1, 0, 0);    // random back-pressure
    tag = "R6"; run(2, 2, 5, 9, 120, 0, 0, 0, 0);    // live pins ignored
    tag = "R7"; run(1, 1, 1, 1, 23, 0, 1, 0, 0);     // stop mid-window
    tag = "R7"; run(2, 3, 2, 3, 60, 0, 0, 0, 0);     // fresh state after
    tag = "R10"; run(6, 0, 6, 0, 40, 0, 0, 0, 0);
    tag = "R10"; run(7, 2, 7, 2, 40, 0, 0, 0, 0);
    tag = "R8"; run(5, 1023, 5, 1023, 6 * 1024 + 8, 0, 0, 1, -2);
    tag = "R8"; run(5, 1023, 5, 1023, 6 * 1024 + 8, 0, 0, 1, 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired tag=%s actual=0 expected=1", tag);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule